// File: doc/BRIEF.md
# Clock Source and Divider Controller

This block is the clock controller of a small microcontroller. It works entirely in one fast base clock domain. Three clock sources (a main crystal, a sub crystal and a low-speed on-chip oscillator) reach it as single-cycle tick strobes. One of them is chosen as the system clock. From that system clock the block derives a divided CPU clock enable and five peripheral prescaler enables. Independently of all of this, it produces a divide-by-128 enable from the low-speed oscillator ticks. Every output is a registered one-cycle enable strobe, never a gated clock.

Software programs the block through a small write port with two registers. The configuration register holds the source select, the CPU divide controls, the oscillator-off bit and the peripheral-stop field. The power register holds the wait request, the stop request and a bit that keeps the divider unchanged on stop. A wake input ends either low-power mode. Changes of source or ratio wait for the end of the current CPU period, so no enable pulse is ever cut short or doubled.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset, all outputs are low. The system clock is the low-speed oscillator and the CPU ratio is 1, so every low-speed tick gives a CPU strobe.
- R2: A write with wr_addr=0 loads the configuration register. Bits [1:0] select the source: 00 is low-speed, 01 is main, 10 is sub, 11 is low-speed. Bit 2 is the divide-by-8 mode bit, bits [4:3] are the divide field, bit 5 turns the low-speed oscillator off, and bits [7:6] are the peripheral-stop field. Only ticks of the selected source advance the system clock.
- R3: The CPU ratio is 8 when bit 2 is 1. Otherwise the divide field gives 1, 2, 4 or 16 for the values 00, 01, 10 and 11. cpu_en pulses once for every ratio system ticks.
- R4: A new source or ratio takes effect only when the CPU divider is at the start of a period. A period that has already started completes at its old ratio.
- R5: per_en[0..4] pulse on every 1st, 2nd, 4th, 8th and 32nd system tick. A slower strobe always coincides with all faster ones.
- R6: A write with wr_addr=1 sets wait from bit 0, stop from bit 1 and the keep-divider bit from bit 2. In wait, cpu_en is silent. per_en is silent only when the peripheral-stop field is not 00.
- R7: In stop, cpu_en and per_en are silent. A stop entry written with keep-divider 0 sets the divide-by-8 mode bit. With keep-divider 1, the ratio stays as it was.
- R8: lso128_en pulses on every 128th low-speed tick, whatever the source, ratio, wait or stop state. While the oscillator-off bit is 1, low-speed ticks are ignored both here and as a system clock.
- R9: wake clears wait and stop on the next edge and has priority over a simultaneous power write. The CPU and peripheral counters restart from zero, so the first strobe after wake comes a full period later.
- R10: Each strobe is registered. It appears in the cycle after the tick that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main crystal tick strobe |
| sub_tick | input | 1 | Sub crystal tick strobe |
| lso_tick | input | 1 | Low-speed oscillator tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration, 1 = power control |
| wr_data | input | 8 | Write data |
| wake | input | 1 | Ends wait and stop |
| cpu_en | output | 1 | CPU clock enable strobe |
| per_en | output | 5 | Peripheral enables, divide by 1, 2, 4, 8, 32 |
| lso128_en | output | 1 | Low-speed divide-by-128 enable |

## Verification
The assertions check on every cycle that stop and wait silence the strobes they govern, and that the peripheral strobes nest. They also check that stop entry without keep-divider leaves the divide-by-8 bit set, that a ratio of 1 answers every tick, and that the divide-by-128 strobe only follows an enabled low-speed tick. Only the bench scenarios can show the strobe counts over whole periods. These include ratios switched mid-period, the full-period restart after wake, the forced divide-by-8 after a stop, and the divide-by-128 branch counting through wait. The bench compares every cycle against a reference model under random source ticks, writes and wakes.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    SRC_LSO  = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;

  // configuration register, MSB first
  typedef struct packed {
    logic [1:0] pstop;
    logic       lso_off;
    logic [1:0] dsel;
    logic       dmode;
    src_e       src;
  } cfg_t;

  // power control register, MSB first
  typedef struct packed {
    logic keep;
    logic stop;
    logic wt;
  } pwr_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam int PWR_W = $bits(pwr_t);

  // log2 of the CPU divide ratio
  function automatic logic [2:0] div_log(input logic dmode, input logic [1:0] dsel);
    if (dmode) return 3'd3;
    case (dsel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake,
  output cfg_t              cfg_q,
  output logic              wt_q,
  output logic              stop_q,
  output logic              keep_q
);

  pwr_t wpwr;
  assign wpwr = pwr_t'(wr_data[PWR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      wt_q   <= 1'b0;
      stop_q <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      if (wr_en && !wr_addr) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_en && wr_addr) begin
        keep_q <= wpwr.keep;
        wt_q   <= wpwr.wt;
        stop_q <= wpwr.stop;
        // stop entry rewrites the divider to /8 unless told to keep it
        if (wpwr.stop && !wpwr.keep && !wake) cfg_q.dmode <= 1'b1;
      end
      if (wake) begin
        wt_q   <= 1'b0;
        stop_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/clkgen_cpu_div.sv
module clkgen_cpu_div
  import clkgen_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  src_e       cfg_src,
  input  logic       cfg_dmode,
  input  logic [1:0] cfg_dsel,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       lso_g,
  input  logic       halt,
  output logic       sys_tick,
  output logic [2:0] eff_log,
  output logic       cpu_en
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  src_e             act_src, eff_src;
  logic [2:0]       act_log;
  logic             at_start, last;

  // a new setting is only adopted while no period is in progress
  assign at_start = (cnt == '0);
  assign eff_src  = at_start ? cfg_src : act_src;
  assign eff_log  = at_start ? div_log(cfg_dmode, cfg_dsel) : act_log;

  always_comb begin
    case (eff_src)
      SRC_MAIN: sys_tick = main_tick;
      SRC_SUB:  sys_tick = sub_tick;
      default:  sys_tick = lso_g;
    endcase
  end

  assign lim  = (CNT_W'(1) << eff_log) - CNT_W'(1);
  assign last = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_src <= SRC_LSO;
      act_log <= 3'd0;
      cpu_en  <= 1'b0;
    end else begin
      act_src <= eff_src;
      act_log <= eff_log;
      cpu_en  <= sys_tick && !halt && last;
      if (halt)          cnt <= '0;
      else if (sys_tick) cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/clkgen_prescaler.sv
module clkgen_prescaler #(
  parameter int TOP_EXP  = 5,
  parameter int NUM_TAPS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_tick,
  input  logic                halt,
  output logic [NUM_TAPS-1:0] per_en
);

  localparam int PW = (TOP_EXP < 1) ? 1 : TOP_EXP;

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst)           pcnt <= '0;
    else if (halt)     pcnt <= '0;
    else if (sys_tick) pcnt <= pcnt + PW'(1);
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    // taps divide by 2^i, the last one by 2^TOP_EXP
    localparam int EXP = (i < NUM_TAPS - 1) ? i : TOP_EXP;
    localparam logic [PW-1:0] MASK = PW'((64'd1 << EXP) - 64'd1);
    always_ff @(posedge clk) begin
      if (rst) per_en[i] <= 1'b0;
      else     per_en[i] <= sys_tick && !halt && ((pcnt & MASK) == MASK);
    end
  end

endmodule

// File: rtl/clkgen_lso_div.sv
module clkgen_lso_div #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic lso_g,
  output logic lso_en
);

  localparam int LW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [LW-1:0] TOP = LW'(DIV - 1);

  logic [LW-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt   <= '0;
      lso_en <= 1'b0;
    end else begin
      lso_en <= lso_g && (lcnt == TOP);
      if (lso_g) lcnt <= (lcnt == TOP) ? '0 : lcnt + LW'(1);
    end
  end

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CPU_CNT_W = 4,
  parameter int PRE_EXP   = 5,
  parameter int PRE_TAPS  = 5,
  parameter int LSO_DIV   = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                main_tick,
  input  logic                sub_tick,
  input  logic                lso_tick,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wake,
  output logic                cpu_en,
  output logic [PRE_TAPS-1:0] per_en,
  output logic                lso128_en
);

  cfg_t       cfg_q;
  logic       wt_q, stop_q, keep_q;
  logic       lso_g, halt_cpu, halt_per, sys_tick;
  logic [2:0] eff_log;

  assign lso_g    = lso_tick && !cfg_q.lso_off;
  assign halt_cpu = wt_q || stop_q;
  assign halt_per = stop_q || (wt_q && (cfg_q.pstop != 2'b00));

  clkgen_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake(wake), .cfg_q(cfg_q), .wt_q(wt_q), .stop_q(stop_q), .keep_q(keep_q)
  );

  clkgen_cpu_div #(.CNT_W(CPU_CNT_W)) u_cpu (
    .clk(clk), .rst(rst), .cfg_src(cfg_q.src), .cfg_dmode(cfg_q.dmode),
    .cfg_dsel(cfg_q.dsel), .main_tick(main_tick), .sub_tick(sub_tick),
    .lso_g(lso_g), .halt(halt_cpu), .sys_tick(sys_tick), .eff_log(eff_log),
    .cpu_en(cpu_en)
  );

  clkgen_prescaler #(.TOP_EXP(PRE_EXP), .NUM_TAPS(PRE_TAPS)) u_pre (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .halt(halt_per), .per_en(per_en)
  );

  clkgen_lso_div #(.DIV(LSO_DIV)) u_lso (
    .clk(clk), .rst(rst), .lso_g(lso_g), .lso_en(lso128_en)
  );

endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk
  import clkgen_pkg::*;
#(
  parameter int PRE_TAPS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                lso_tick,
  input cfg_t                cfg_q,
  input logic                wt_q,
  input logic                stop_q,
  input logic                keep_q,
  input logic                halt_cpu,
  input logic                sys_tick,
  input logic [2:0]          eff_log,
  input logic                cpu_en,
  input logic [PRE_TAPS-1:0] per_en,
  input logic                lso128_en
);

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    stop_q |=> (!cpu_en && per_en == '0)); // R7

  AST_STOP_FORCE_DIV8: assert property (@(posedge clk) disable iff (rst)
    ($rose(stop_q) && !keep_q) |-> cfg_q.dmode); // R7

  AST_WAIT_CPU_QUIET: assert property (@(posedge clk) disable iff (rst)
    wt_q |=> !cpu_en); // R6

  AST_WAIT_PER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wt_q && cfg_q.pstop != 2'b00) |=> per_en == '0); // R6

  AST_UNIT_RATIO: assert property (@(posedge clk) disable iff (rst)
    (eff_log == 3'd0 && sys_tick && !halt_cpu) |=> cpu_en); // R3

  AST_CPU_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> $past(sys_tick)); // R10

  AST_LSO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    lso128_en |-> $past(lso_tick && !cfg_q.lso_off)); // R8

  for (genvar i = 0; i + 1 < PRE_TAPS; i++) begin : g_nest
    AST_TAP_NEST: assert property (@(posedge clk) disable iff (rst)
      per_en[i+1] |-> per_en[i]); // R5
  end

endmodule

bind clkgen_ctrl clkgen_ctrl_chk #(.PRE_TAPS(PRE_TAPS)) u_chk (
  .clk(clk), .rst(rst), .lso_tick(lso_tick), .cfg_q(cfg_q), .wt_q(wt_q),
  .stop_q(stop_q), .keep_q(keep_q), .halt_cpu(halt_cpu), .sys_tick(sys_tick),
  .eff_log(eff_log), .cpu_en(cpu_en), .per_en(per_en), .lso128_en(lso128_en)
);

// File: tb/clkgen_ctrl_test.sv
module clkgen_ctrl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_tick = 1'b0, sub_tick = 1'b0, lso_tick = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, wake = 1'b0;
  logic [7:0] wr_data = '0;
  logic cpu_en, lso128_en;
  logic [4:0] per_en;

  always #2.5 clk = ~clk;

  clkgen_ctrl uut (
    .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
    .lso_tick(lso_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake(wake), .cpu_en(cpu_en), .per_en(per_en), .lso128_en(lso128_en)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  logic [7:0] m_cfg;
  bit m_wt, m_stop;
  int m_cnt, m_act_src, m_act_log, m_pcnt, m_lcnt;
  bit e_cpu, e_lso;
  bit [4:0] e_per;
  int o_cpu, o_lso;
  int o_per[5];

  function automatic int ref_log(bit dm, bit [1:0] ds);
    if (dm) return 3;
    return (ds == 2'd3) ? 4 : int'(ds);
  endfunction

  task automatic chk(string t, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cfg = '0; m_wt = 0; m_stop = 0;
    m_cnt = 0; m_act_src = 0; m_act_log = 0; m_pcnt = 0; m_lcnt = 0;
    e_cpu = 0; e_lso = 0; e_per = '0;
  endtask

  task automatic step(bit mt, bit st, bit lt, bit we, bit ad, logic [7:0] d, bit wk);
    bit lg, hc, hp, bnd, sys, last;
    int es, el, lim;
    @(negedge clk);
    chk(tag, "cpu_en", cpu_en, e_cpu);
    chk(tag, "per_en", per_en, e_per);
    chk(tag, "lso128_en", lso128_en, e_lso);
    o_cpu += int'(cpu_en); o_lso += int'(lso128_en);
    for (int i = 0; i < 5; i++) o_per[i] += int'(per_en[i]);
    main_tick = mt; sub_tick = st; lso_tick = lt;
    wr_en = we; wr_addr = ad; wr_data = d; wake = wk;
    lg  = lt && !m_cfg[5];
    hc  = m_wt || m_stop;
    hp  = m_stop || (m_wt && m_cfg[7:6] != 2'b00);
    bnd = (m_cnt == 0);
    es  = bnd ? int'(m_cfg[1:0]) : m_act_src;
    el  = bnd ? ref_log(m_cfg[2], m_cfg[4:3]) : m_act_log;
    sys = (es == 1) ? mt : (es == 2) ? st : lg;
    lim = (1 << el) - 1;
    last = (m_cnt == lim);
    e_cpu = sys && !hc && last;
    for (int i = 0; i < 5; i++) begin
      int m;
      m = (1 << ((i < 4) ? i : 5)) - 1;
      e_per[i] = sys && !hp && ((m_pcnt & m) == m);
    end
    e_lso = lg && (m_lcnt == 127);
    m_cnt = hc ? 0 : (sys ? (last ? 0 : m_cnt + 1) : m_cnt);
    m_act_src = es; m_act_log = el;
    m_pcnt = hp ? 0 : (sys ? (m_pcnt + 1) % 32 : m_pcnt);
    if (lg) m_lcnt = (m_lcnt == 127) ? 0 : m_lcnt + 1;
    if (we && !ad) m_cfg = d;
    if (we && ad) begin
      m_wt = d[0]; m_stop = d[1];
      if (d[1] && !d[2] && !wk) m_cfg[2] = 1'b1;
    end
    if (wk) begin m_wt = 0; m_stop = 0; end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 8'h00, 0); endtask
  task automatic wcfg(logic [7:0] d); step(0, 0, 0, 1, 0, d, 0); endtask
  task automatic wpwr(logic [7:0] d); step(0, 0, 0, 1, 1, d, 0); endtask
  task automatic do_wake(); step(0, 0, 0, 0, 0, 8'h00, 1); endtask
  task automatic pump(int n, bit mt, bit st, bit lt);
    for (int i = 0; i < n; i++) step(mt, st, lt, 0, 0, 8'h00, 0);
  endtask
  task automatic zero_obs();
    o_cpu = 0; o_lso = 0;
    for (int i = 0; i < 5; i++) o_per[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; main_tick = 0; sub_tick = 0; lso_tick = 0;
    wr_en = 0; wr_addr = 0; wr_data = '0; wake = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1 reset state and ratio 1 on the low-speed clock
    tag = "R1";
    chk("R1", "reset cpu_en", cpu_en, 0);
    chk("R1", "reset per_en", per_en, 0);
    chk("R1", "reset lso128_en", lso128_en, 0);
    zero_obs(); pump(10, 0, 0, 1); idle();
    chk("R1", "cpu strobes per lso tick", o_cpu, 10);

    // R10 one-cycle latency
    tag = "R10";
    pump(1, 0, 0, 1); zero_obs(); idle();
    chk("R10", "strobe in next cycle", o_cpu, 1);

    // R2 source select: main only
    tag = "R2";
    do_reset(); wcfg(8'b00_0_01_0_01);
    zero_obs();
    for (int i = 0; i < 32; i++) step(i % 2 == 0, 1, 1, 0, 0, 8'h00, 0);
    idle();
    chk("R2", "main /2 with main on half the cycles", o_cpu, 8);
    do_reset(); wcfg(8'b00_0_00_0_10);
    zero_obs(); pump(20, 1, 0, 1); idle();
    chk("R2", "sub source ignores other ticks", o_cpu, 0);

    // R3 divide ratios
    tag = "R3";
    for (int k = 0; k < 5; k++) begin
      logic [7:0] d;
      int r;
      d = (k == 4) ? 8'b00_0_00_1_01 : {3'b000, 2'(k), 1'b0, 2'b01};
      r = (k == 4) ? 8 : (k == 3) ? 16 : (1 << k);
      do_reset(); wcfg(d);
      zero_obs(); pump(64, 1, 0, 0); idle();
      chk("R3", "cpu strobes over 64 ticks", o_cpu, 64 / r);
    end

    // R4 ratio change mid-period waits for the boundary
    tag = "R4";
    do_reset(); wcfg(8'b00_0_11_0_01);
    zero_obs(); pump(5, 1, 0, 0);
    wcfg(8'b00_0_01_0_01);
    pump(17, 1, 0, 0); idle();
    chk("R4", "old /16 period completes then /2", o_cpu, 4);

    // R5 peripheral taps
    tag = "R5";
    do_reset(); wcfg(8'b00_0_00_0_01);
    zero_obs(); pump(64, 1, 0, 0); idle();
    chk("R5", "f1 count", o_per[0], 64);
    chk("R5", "f2 count", o_per[1], 32);
    chk("R5", "f4 count", o_per[2], 16);
    chk("R5", "f8 count", o_per[3], 8);
    chk("R5", "f32 count", o_per[4], 2);

    // R6 wait with and without peripheral stop; R8 lso128 runs through wait
    tag = "R6";
    do_reset(); wcfg(8'b01_0_00_0_01); wpwr(8'h01);
    zero_obs(); pump(128, 1, 0, 1); idle();
    chk("R6", "cpu silent in wait", o_cpu, 0);
    chk("R6", "per silent with field 01", o_per[0], 0);
    chk("R8", "lso128 through wait", o_lso, 1);
    do_wake(); wcfg(8'b00_0_00_0_01); wpwr(8'h01);
    zero_obs(); pump(16, 1, 0, 0); idle();
    chk("R6", "per runs with field 00", o_per[0], 16);
    chk("R6", "cpu still silent", o_cpu, 0);

    // R7 stop forces /8 unless kept
    tag = "R7";
    do_reset(); wcfg(8'b00_0_00_0_01); wpwr(8'h02);
    zero_obs(); pump(20, 1, 1, 0); idle();
    chk("R7", "all silent in stop", o_cpu + o_per[0], 0);
    do_wake(); zero_obs(); pump(64, 1, 0, 0); idle();
    chk("R7", "forced /8 after stop", o_cpu, 8);
    do_reset(); wcfg(8'b00_0_00_0_01); wpwr(8'h06);
    pump(5, 1, 0, 0); do_wake();
    zero_obs(); pump(64, 1, 0, 0); idle();
    chk("R7", "keep bit retains /1", o_cpu, 64);

    // R8 oscillator off
    tag = "R8";
    do_reset(); wcfg(8'b00_1_00_0_00);
    zero_obs(); pump(300, 0, 0, 1); idle();
    chk("R8", "lso128 silent when off", o_lso, 0);
    chk("R8", "lso source silent when off", o_cpu, 0);
    wcfg(8'h00); zero_obs(); pump(256, 0, 0, 1); idle();
    chk("R8", "lso128 every 128", o_lso, 2);

    // R9 wake restarts a full period; wake beats a power write
    tag = "R9";
    do_reset(); wcfg(8'b00_0_10_0_01);
    pump(2, 1, 0, 0); wpwr(8'h01); pump(3, 1, 0, 0); do_wake();
    zero_obs(); pump(3, 1, 0, 0); idle();
    chk("R9", "no strobe before full period", o_cpu, 0);
    zero_obs(); pump(1, 1, 0, 0); idle();
    chk("R9", "strobe at end of full period", o_cpu, 1);
    step(0, 0, 0, 1, 1, 8'h02, 1);
    zero_obs(); pump(4, 1, 0, 0); idle();
    chk("R9", "wake wins over stop write", o_cpu, 1);

    // R4 random mix, model compared on every cycle
    tag = "R4";
    do_reset();
    void'($urandom(32'h5EED_C10C));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3)
        step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1, 1, 0,
             8'($urandom) & 8'hDF, 0);
      else if (r < 4)
        step(1, 1, 1, 1, 1, 8'($urandom_range(0, 7)), 0);
      else if (r < 7)
        step(1, 0, 1, 0, 0, 8'h00, 1);
      else
        step($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 1) == 1, 0, 0, 8'h00, 0);
    end
    idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule